// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Period

The block is a 16-bit up-counter that drives two pulse-width-modulated outputs. It counts on every cycle where the tick enable is high. When it reaches the current period limit (TOP) it returns to zero on the next tick. The limit comes from one of five sources, picked by a mode field: three fixed resolutions (8, 9 and 10 bits), a period register written directly, or the active value of compare channel A. Each of the two compare channels has its own output mode: held low, non-inverted or inverted.

Software writes through a small register port. Writes to a compare register land in a buffer, and the buffer moves to the active compare value on the tick where the counter wraps at TOP. Changing the period through channel A therefore takes effect cleanly at the end of the running period. The period register has no buffer. If it is written with a value below the running count, the counter misses TOP, runs to 0xFFFF and wraps before it can match again. Four sticky event flags record overflow, the two compare matches and the period match. Each flag is cleared by writing one to its bit of the clear input.

Top module: `pwm_timer`

## Requirements
- R1: While reset is asserted, the count is 0, both PWM outputs are low and all four flags are 0.
- R2: The count changes only on cycles where tick_i is high. On such a tick it increments by one, except at TOP, where the next value is 0. When TOP is not reached it wraps from 0xFFFF to 0.
- R3: The mode field is ctrl bits [3:0]. Mode 5 gives TOP 0x00FF, mode 6 gives 0x01FF, mode 7 gives 0x03FF, mode 14 takes TOP from the period register and mode 15 takes TOP from the active compare A value. Any other code gives TOP 0xFFFF.
- R4: In modes 5, 6 and 7, a compare write stores only the bits inside the mode's resolution. The bits above it are stored as zero.
- R5: A compare write goes to a buffer. The active compare value takes the buffer contents only on a tick where the count is at TOP. In mode 15 a new period written mid-period therefore applies from the following period.
- R6: The period register takes effect as soon as it is written. If it is written below the running count, the counter continues to 0xFFFF, wraps to 0 and only then matches the new TOP.
- R7: flags_o bit 0 sets on every tick at TOP. Bit 1 sets on a tick where the count equals the active compare A value, and bit 2 does the same for compare B. Bit 3 sets on a tick at TOP in mode 14. Flags stay set until a 1 on the matching bit of flag_clr_i clears them. A new set in the same cycle wins over the clear.
- R8: The output modes are ctrl bits [5:4] for channel A and bits [7:6] for channel B. Code 2 gives a non-inverted output: it goes high on the wrap at TOP and low on a compare match. Code 3 gives the complement. Codes 0 and 1 hold the output low.
- R9: A channel whose active compare value lies above TOP never matches while the count stays within TOP. In non-inverted mode its output then stays high for the whole period.
- R10: For a fixed TOP and compare value C no larger than TOP, a non-inverted output is high for C+1 of every TOP+1 ticks. This gives 1 tick for C=0 and a constant high for C=TOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 ctrl, 1 compare A, 2 compare B, 3 period |
| wr_data_i | input | 16 | Write data |
| flag_clr_i | input | 4 | Write-one-to-clear mask for flags_o |
| cnt_o | output | 16 | Current count |
| pwm_a_o | output | 1 | Channel A waveform |
| pwm_b_o | output | 1 | Channel B waveform |
| flags_o | output | 4 | Sticky flags: 0 overflow, 1 compare A, 2 compare B, 3 period match |

## Verification
The counter is first driven with a continuous tick and then with a tick that drops out every fifth cycle. This separates counting on the clock from counting on the enable. Duty cycles are measured at compare values of zero, mid-scale and TOP, which exposes off-by-one errors at each end of the set/clear ordering. A compare written with bits above the 8-bit resolution shows whether masking happens at write time. A period change in mode 15 made in the middle of a period, followed by a period register written below the running count, tells buffered loading apart from immediate loading and shows the missed-TOP run to 0xFFFF.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam logic [3:0] MODE_FIX0   = 4'd5;
  localparam logic [3:0] MODE_FIX1   = 4'd6;
  localparam logic [3:0] MODE_FIX2   = 4'd7;
  localparam logic [3:0] MODE_PERIOD = 4'd14;
  localparam logic [3:0] MODE_CMPA   = 4'd15;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_CMPA   = 2'd1;
  localparam logic [1:0] ADDR_PERIOD = 2'd3;

  typedef enum logic [1:0] {
    OUT_OFF0   = 2'd0,
    OUT_OFF1   = 2'd1,
    OUT_NONINV = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_e;

  localparam int unsigned FLG_OVF = 0;
  localparam int unsigned FLG_CMP = 1;  // channel c uses FLG_CMP + c
  localparam int unsigned FLG_PER = 3;
  localparam int unsigned NFLG    = 4;
endpackage

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         at_top_o
);
  logic [W-1:0] cnt_q;

  assign at_top_o = (cnt_q == top_i);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (tick_i) begin
      if (at_top_o)    cnt_q <= '0;
      else             cnt_q <= cnt_q + W'(1);
    end
  end

  assert_hold_no_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  assert_clear_after_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && at_top_o) |=> (cnt_q == '0));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !at_top_o) |=> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan
  import pwm_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         at_top_i,
  input  logic [W-1:0] cnt_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] mask_i,
  input  logic [1:0]   out_mode_i,
  output logic [W-1:0] cmp_o,
  output logic         match_o,
  output logic         pwm_o
);
  logic [W-1:0] buf_q, act_q;
  logic         lvl_q;  // non-inverted level: set at wrap, cleared on match

  assign match_o = tick_i && (cnt_i == act_q);
  assign cmp_o   = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (wr_i) buf_q <= wdata_i & mask_i;
      if (tick_i && at_top_i) begin
        act_q <= buf_q;
        lvl_q <= 1'b1;
      end else if (match_o) begin
        lvl_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (out_mode_e'(out_mode_i))
      OUT_NONINV: pwm_o = lvl_q;
      OUT_INV:    pwm_o = ~lvl_q;
      default:    pwm_o = 1'b0;
    endcase
  end

  assert_buf_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((buf_q & ~$past(mask_i)) == '0));
  assert_set_at_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && at_top_i) |=> lvl_q);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned FIX_RES0 = 8,
  parameter int unsigned FIX_RES1 = 9,
  parameter int unsigned FIX_RES2 = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [3:0]    flag_clr_i,
  output logic [W-1:0]  cnt_o,
  output logic          pwm_a_o,
  output logic          pwm_b_o,
  output logic [3:0]    flags_o
);
  localparam int unsigned NCH = 2;
  localparam logic [W-1:0] FIX_TOP0 = W'((32'd1 << FIX_RES0) - 32'd1);
  localparam logic [W-1:0] FIX_TOP1 = W'((32'd1 << FIX_RES1) - 32'd1);
  localparam logic [W-1:0] FIX_TOP2 = W'((32'd1 << FIX_RES2) - 32'd1);

  logic [3:0]      mode_q;
  logic [1:0]      om_q [NCH];
  logic [W-1:0]    period_q;
  logic [W-1:0]    top, wmask, cnt;
  logic            at_top;
  logic [W-1:0]    cmp_act [NCH];
  logic [NCH-1:0]  match, pwm;
  logic [NFLG-1:0] flags_q, flag_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      period_q <= '0;
      for (int c = 0; c < NCH; c++) om_q[c] <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_CTRL) begin
        mode_q <= wr_data_i[3:0];
        for (int c = 0; c < NCH; c++) om_q[c] <= wr_data_i[4+2*c +: 2];
      end
      if (wr_addr_i == ADDR_PERIOD) period_q <= wr_data_i;
    end
  end

  always_comb begin
    wmask = '1;
    unique case (mode_q)
      MODE_FIX0:   begin top = FIX_TOP0; wmask = FIX_TOP0; end
      MODE_FIX1:   begin top = FIX_TOP1; wmask = FIX_TOP1; end
      MODE_FIX2:   begin top = FIX_TOP2; wmask = FIX_TOP2; end
      MODE_PERIOD: top = period_q;
      MODE_CMPA:   top = cmp_act[0];
      default:     top = '1;
    endcase
  end

  pwm_tick_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .top_i    (top),
    .cnt_o    (cnt),
    .at_top_o (at_top)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_cmp_chan #(.W(W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .at_top_i   (at_top),
      .cnt_i      (cnt),
      .wr_i       (wr_en_i && (wr_addr_i == (ADDR_CMPA + 2'(c)))),
      .wdata_i    (wr_data_i),
      .mask_i     (wmask),
      .out_mode_i (om_q[c]),
      .cmp_o      (cmp_act[c]),
      .match_o    (match[c]),
      .pwm_o      (pwm[c])
    );
    assign flag_set[FLG_CMP+c] = match[c];

    assert_cmp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(tick_i && at_top) |=> $stable(cmp_act[c]));
  end

  assign flag_set[FLG_OVF] = tick_i && at_top;
  assign flag_set[FLG_PER] = tick_i && at_top && (mode_q == MODE_PERIOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr_i) | flag_set;
  end

  assign cnt_o   = cnt;
  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];
  assign flags_o = flags_q;

  assert_ovf_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && at_top) |=> flags_q[FLG_OVF]);
  assert_per_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && at_top && mode_q == MODE_PERIOD) |=> flags_q[FLG_PER]);
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[FLG_OVF] && !flag_clr_i[FLG_OVF]) |=> flags_q[FLG_OVF]);
endmodule

// File: tb/pwm_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_timer_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [3:0]  flag_clr_i = '0;
  logic [15:0] cnt_o;
  logic        pwm_a_o, pwm_b_o;
  logic [3:0]  flags_o;

  pwm_timer dut_i (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, tick_en = 1, tick_pat = 0;
  int tcnt = 0;

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model state
  int m_cnt, m_mode, m_per;
  int m_om [2], m_buf [2], m_act [2];
  bit m_st [2];
  bit [3:0] m_flags;

  function automatic int m_top();
    case (m_mode)
      5: return 255; 6: return 511; 7: return 1023;
      14: return m_per; 15: return m_act[0];
      default: return 65535;
    endcase
  endfunction
  function automatic int m_mask();
    case (m_mode)
      5: return 255; 6: return 511; 7: return 1023;
      default: return 65535;
    endcase
  endfunction
  function automatic bit m_pwm(int c);
    if (m_om[c] == 2) return m_st[c];
    if (m_om[c] == 3) return !m_st[c];
    return 1'b0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_mode = 0; m_per = 0; m_flags = 0;
      for (int c = 0; c < 2; c++) begin m_om[c] = 0; m_buf[c] = 0; m_act[c] = 0; m_st[c] = 0; end
    end else begin
      int top, msk;
      bit wrap;
      bit [3:0] set;
      bit mt [2];
      top = m_top(); msk = m_mask();
      wrap = tick_i && (m_cnt == top);
      set = 0;
      set[0] = wrap;
      set[3] = wrap && (m_mode == 14);
      for (int c = 0; c < 2; c++) begin
        mt[c] = tick_i && (m_cnt == m_act[c]);
        set[1+c] = mt[c];
      end
      m_flags = (m_flags & ~flag_clr_i) | set;
      for (int c = 0; c < 2; c++) begin
        if (wrap) begin m_st[c] = 1; m_act[c] = m_buf[c]; end
        else if (mt[c]) m_st[c] = 0;
      end
      if (wr_en_i) begin
        case (wr_addr_i)
          2'd0: begin m_mode = wr_data_i[3:0]; m_om[0] = wr_data_i[5:4]; m_om[1] = wr_data_i[7:6]; end
          2'd1: m_buf[0] = wr_data_i & msk;
          2'd2: m_buf[1] = wr_data_i & msk;
          default: m_per = wr_data_i;
        endcase
      end
      if (tick_i) m_cnt = wrap ? 0 : (m_cnt + 1) & 65535;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk_i) begin
    if (cmp_on) begin
      chk("R2", cnt_o, m_cnt, "count vs model");
      chk("R7", flags_o, m_flags, "flags vs model");
      chk("R8", pwm_a_o, m_pwm(0), "pwm A vs model");
      chk("R8", pwm_b_o, m_pwm(1), "pwm B vs model");
    end
    tick_i = tick_pat ? ((tcnt % 5) != 2) : tick_en;
    tcnt++;
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i); wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask
  task automatic clr(input logic [3:0] m);
    @(negedge clk_i); flag_clr_i = m;
    @(negedge clk_i); flag_clr_i = 0;
  endtask
  task automatic wait_cnt(input int v);
    do @(negedge clk_i); while (cnt_o != v);
  endtask
  task automatic duty_a(output int hi, input int top);
    wait_cnt(0);
    hi = 0;
    repeat (top + 1) begin
      if (pwm_a_o) hi++;
      @(negedge clk_i);
    end
  endtask
  // runs until the count returns to 0, reporting the highest count seen
  task automatic period_max(output int mx);
    mx = cnt_o;
    do begin
      @(negedge clk_i);
      if (cnt_o > mx) mx = cnt_o;
    end while (cnt_o != 0);
  endtask

  initial begin
    #950000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi, mx, f;
    bit b_low;
    repeat (4) @(negedge clk_i);
    chk("R1", cnt_o, 0, "count in reset");
    chk("R1", {pwm_a_o, pwm_b_o}, 0, "outputs in reset");
    chk("R1", flags_o, 0, "flags in reset");
    rst_ni = 1;
    cmp_on = 1;

    // mode 5, A non-inverted, B inverted
    wr(2'd0, 16'd5 | (16'd2 << 4) | (16'd3 << 6));
    wr(2'd1, 16'h0180);                    // R4: stored as 0x80
    wr(2'd2, 16'h01F0);                    // R4: stored as 0xF0
    wait_cnt(255);
    duty_a(hi, 255);
    chk("R10", hi, 129, "duty mid value");
    clr(4'hF);
    wait_cnt(16'hF2);
    chk("R4", flags_o[2], 1, "masked compare B matched at 0xF0");
    wr(2'd1, 16'd0);
    wait_cnt(255);
    duty_a(hi, 255);
    chk("R10", hi, 1, "duty C=0");
    wr(2'd1, 16'd255);
    wait_cnt(255);
    duty_a(hi, 255);
    chk("R10", hi, 256, "duty C=TOP");

    // R2: gapped ticks and halted ticks
    tick_pat = 1;
    repeat (700) @(negedge clk_i);
    tick_pat = 0; tick_en = 0;
    @(negedge clk_i); f = cnt_o;
    repeat (10) @(negedge clk_i);
    chk("R2", cnt_o, f, "count held without tick");
    tick_en = 1;

    // R3: other fixed tops
    wr(2'd0, 16'd6 | (16'd2 << 4));
    wait_cnt(511); @(negedge clk_i);
    chk("R3", cnt_o, 0, "mode 6 wraps after 0x1FF");
    wr(2'd0, 16'd7 | (16'd2 << 4));
    wait_cnt(1023); @(negedge clk_i);
    chk("R3", cnt_o, 0, "mode 7 wraps after 0x3FF");

    // R5: buffered TOP through compare A (active A is 255 now)
    wr(2'd0, 16'd15 | (16'd2 << 4));
    wr(2'd1, 16'd99);
    wait_cnt(0);
    wait_cnt(20);
    wr(2'd1, 16'd49);
    period_max(mx);
    chk("R5", mx, 99, "old TOP kept after mid-period write");
    period_max(mx);
    chk("R5", mx, 49, "new TOP applied next period");

    // R6: unbuffered period written below count
    wr(2'd3, 16'd300);
    wr(2'd0, 16'd14 | (16'd2 << 4) | (16'd2 << 6));
    wait_cnt(200);
    wr(2'd3, 16'd100);
    period_max(mx);
    chk("R6", mx, 65535, "missed TOP runs to 0xFFFF");
    clr(4'hF);
    period_max(mx);
    chk("R6", mx, 100, "new period after wrap");
    chk("R7", flags_o[3], 1, "period match flag");

    // R9: compare B above TOP
    wr(2'd2, 16'd200);
    wait_cnt(100);
    wait_cnt(1);
    clr(4'hF);
    b_low = 0;
    repeat (101) begin
      @(negedge clk_i);
      if (!pwm_b_o) b_low = 1;
    end
    chk("R9", flags_o[2], 0, "no match above TOP");
    chk("R9", b_low, 0, "output stays high");

    // R7: write-one-to-clear with ticks halted
    tick_en = 0;
    @(negedge clk_i);
    clr(4'hF);
    chk("R7", flags_o, 0, "flags cleared");

    // R8: output modes 0 and 1 hold low
    tick_en = 1;
    wr(2'd0, 16'd14 | (16'd1 << 4));
    repeat (150) @(negedge clk_i);
    chk("R8", {pwm_a_o, pwm_b_o}, 0, "disconnected outputs low");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule